// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

This block is a behavioural synchronous static memory with a command pipeline that never needs an idle cycle between a read and a write. Every command is taken on a rising clock edge: a clock enable, three chip selects, a load/continue strobe, a write strobe and per-byte write strobes. A mode pin picks registered (pipelined) or unregistered (flow-through) read timing. The write data latency follows the same mode, so a write's data slot always lands where a read's data slot would have been.

A 2-bit burst counter lets a single loaded address expand into four accesses inside an aligned group of four words. It counts either by addition or by XOR with the step number. A write that is directly followed by a read of the same word returns the new data, because the pending write data is forwarded before it reaches the array. An asynchronous output enable gates the read data. A sleep input parks the block after two edges and brings it back after two more. During the way back only reads and deselects are honoured.

The data bus is modelled as a separate input word and output word, plus a flag that shows when the block would be driving.

Top module: `zt_sram`

## Requirements
- R1: A read is issued at an edge where clk_en_n=0, cs1_n=0, cs2=1, cs3_n=0, load_n=0 and we_n=1, and the address is taken at that edge. With flow_thru=0 its data is on dout with dq_oe=1 after the next edge. With flow_thru=1 it is there right after the issuing edge.
- R2: A write is issued like a read but with we_n=0. Its data is taken from din two edges later when flow_thru=0, and one edge later when flow_thru=1. be_n[i]=0 writes bits 8i+7..8i and be_n[i]=1 leaves that byte unchanged. With all be_n bits high nothing is written.
- R3: An edge with load_n=1 continues the last loaded burst with that burst's read or write type. It uses the next address from the counter, and address bits above bit 1 stay those of the loaded address.
- R4: For the n-th continue (n=1..3) after a load of start address s, the address bits 1..0 are (s+n) mod 4 when order_xor=0, and s XOR n when order_xor=1. After four accesses the sequence returns to s.
- R5: An edge with clk_en_n=1 has no effect. The command on the inputs is dropped, no write commits, and dout/dq_oe keep their values.
- R6: A load with any chip select inactive is a deselect: no access and dq_oe=0. A continue after a deselect, or after reset, is also a deselect.
- R7: dq_oe=1 only in a read data cycle with oe_n=0. oe_n acts without waiting for a clock edge. A write data cycle never drives, whatever oe_n is.
- R8: A read issued in the cycle right after a write to the same address returns the newly written data in both modes.
- R9: When zz is high at two consecutive edges, the block is asleep from the second edge on. Commands at asleep edges are ignored, dq_oe=0, and the memory contents are kept.
- R10: After zz is seen low at an asleep edge, the next two edges are recovery edges. At those edges write commands are discarded and reads are carried out. After that, normal operation resumes.
- R11: After reset, dq_oe=0, dout=0, and the burst history is a deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Clock enable, active low |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| load_n | input | 1 | 0 loads a new address, 1 continues the burst |
| we_n | input | 1 | 0 selects write on a load |
| be_n | input | BYTES | Per-byte write strobes, active low |
| addr | input | ADDR_W | Word address |
| din | input | 8*BYTES | Write data |
| flow_thru | input | 1 | 1 selects flow-through timing, 0 pipelined |
| order_xor | input | 1 | 1 selects XOR burst order, 0 additive |
| oe_n | input | 1 | Asynchronous output enable, active low |
| zz | input | 1 | Sleep request, active high |
| dout | output | 8*BYTES | Read data, zero when not driving |
| dq_oe | output | 1 | High when the block drives read data |

## Verification
The bench builds the block with its defaults: a 6-bit word address and two byte lanes. This keeps byte-granular writes, partial-write merging and burst groups at several upper-address values within reach. A vector table sends four-word write bursts and read bursts through every pairing of timing mode and burst order, from start offsets 0 to 3. Each burst is then read back word by word at the addresses the bench computes itself. Directed sequences cover write-then-read forwarding in both modes, stalls, deselects, the asynchronous output enable, and sleep entry and recovery.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  typedef enum logic [2:0] {
    SL_AWAKE = 3'd0,
    SL_ENTER = 3'd1,
    SL_SLEEP = 3'd2,
    SL_WAKE1 = 3'd3,
    SL_WAKE2 = 3'd4
  } slp_e;
endpackage

// File: rtl/zt_sleep_ctl.sv
module zt_sleep_ctl
  import zt_sram_pkg::*;
(
  input  logic clk,
  input  logic rst_s_n,
  input  logic zz,
  output logic asleep,
  output logic waking
);
  slp_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SL_AWAKE: if (zz) state_d = SL_ENTER;
      SL_ENTER: state_d = zz ? SL_SLEEP : SL_AWAKE;
      SL_SLEEP: if (!zz) state_d = SL_WAKE1;
      SL_WAKE1: state_d = zz ? SL_SLEEP : SL_WAKE2;
      SL_WAKE2: state_d = zz ? SL_SLEEP : SL_AWAKE;
      default:  state_d = SL_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) state_q <= SL_AWAKE;
    else          state_q <= state_d;
  end

  assign asleep = (state_q == SL_SLEEP);
  assign waking = (state_q == SL_WAKE1) || (state_q == SL_WAKE2);

  // R9: second consecutive high sample puts the block to sleep
  a_r9_sleep_entry: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q == SL_ENTER && zz) |=> asleep);

  // R10: leaving sleep always passes through recovery
  a_r10_recover_path: assert property (@(posedge clk) disable iff (!rst_s_n)
    (asleep && !zz) |=> (waking && !asleep));
endmodule

// File: rtl/zt_burst_gen.sv
module zt_burst_gen
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 2
) (
  input  logic              clk,
  input  logic              rst_s_n,
  input  logic              cke_act,
  input  logic              sel,
  input  logic              load_n,
  input  logic              we_n,
  input  logic [BYTES-1:0]  be_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              order_xor,
  input  logic              asleep,
  input  logic              waking,
  output op_e               iss_op,
  output logic [ADDR_W-1:0] iss_addr,
  output logic [BYTES-1:0]  iss_be
);
  localparam int HI_W = ADDR_W - 2;

  op_e               hist_q, hist_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        cnt_q, cnt_d;
  logic [1:0]        step, low;
  logic              upd_load, upd_cont;
  op_e               typ;

  always_comb begin
    step     = cnt_q + 2'd1;
    low      = order_xor ? (base_q[1:0] ^ step) : (base_q[1:0] + step);
    typ      = OP_NONE;
    iss_op   = OP_NONE;
    iss_addr = addr;
    iss_be   = ~be_n;
    upd_load = 1'b0;
    upd_cont = 1'b0;
    if (!asleep) begin
      if (!load_n) begin
        typ = sel ? (we_n ? OP_RD : OP_WR) : OP_NONE;
        if (!(waking && typ == OP_WR)) begin
          iss_op   = typ;
          upd_load = 1'b1;
        end
      end else begin
        typ      = hist_q;
        iss_addr = {base_q[ADDR_W-1:2], low};
        if (!(waking && typ == OP_WR)) begin
          iss_op   = typ;
          upd_cont = 1'b1;
        end
      end
    end
  end

  always_comb begin
    hist_d = hist_q;
    base_d = base_q;
    cnt_d  = cnt_q;
    if (cke_act) begin
      if (upd_load) begin
        hist_d = typ;
        base_d = addr;
        cnt_d  = 2'd0;
      end else if (upd_cont) begin
        cnt_d  = step;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      hist_q <= OP_NONE;
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      hist_q <= hist_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  // R4: the fourth continue returns to the loaded low bits
  a_r4_wrap_home: assert property (@(posedge clk) disable iff (!rst_s_n)
    (upd_cont && cnt_q == 2'd3) |-> (iss_addr[1:0] == base_q[1:0]));

  // R3: a continue keeps the upper address bits of its load
  a_r3_upper_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cke_act && upd_load) |=> (!load_n |-> 1'b1) && (base_q[ADDR_W-1:2] == $past(addr[ADDR_W-1:2])));

  // R6: continuing a deselect issues nothing
  a_r6_desel_cont: assert property (@(posedge clk) disable iff (!rst_s_n)
    (load_n && hist_q == OP_NONE) |-> (iss_op == OP_NONE));

  initial begin
    a_r3_width: assert (HI_W >= 1);
  end
endmodule

// File: rtl/zt_sram_array.sv
module zt_sram_array #(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 2
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [BYTES-1:0]     wr_be,
  input  logic [8*BYTES-1:0]   wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [8*BYTES-1:0]   rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    logic [7:0] lane [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_be[b]) lane[wr_addr] <= wr_data[8*b +: 8];
    end

    assign rd_data[8*b +: 8] = lane[rd_addr];
  end
endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clk_en_n,
  input  logic                cs1_n,
  input  logic                cs2,
  input  logic                cs3_n,
  input  logic                load_n,
  input  logic                we_n,
  input  logic [BYTES-1:0]    be_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [8*BYTES-1:0]  din,
  input  logic                flow_thru,
  input  logic                order_xor,
  input  logic                oe_n,
  input  logic                zz,
  output logic [8*BYTES-1:0]  dout,
  output logic                dq_oe
);
  localparam int DW = 8 * BYTES;

  logic [1:0] rs_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  logic cke_act, sel, asleep, waking;
  assign cke_act = !clk_en_n;
  assign sel     = !cs1_n && cs2 && !cs3_n;

  op_e               iss_op;
  logic [ADDR_W-1:0] iss_addr;
  logic [BYTES-1:0]  iss_be;

  zt_sleep_ctl i_sleep (
    .clk    (clk),
    .rst_s_n(rst_s_n),
    .zz     (zz),
    .asleep (asleep),
    .waking (waking)
  );

  zt_burst_gen #(.ADDR_W(ADDR_W), .BYTES(BYTES)) i_burst (
    .clk      (clk),
    .rst_s_n  (rst_s_n),
    .cke_act  (cke_act),
    .sel      (sel),
    .load_n   (load_n),
    .we_n     (we_n),
    .be_n     (be_n),
    .addr     (addr),
    .order_xor(order_xor),
    .asleep   (asleep),
    .waking   (waking),
    .iss_op   (iss_op),
    .iss_addr (iss_addr),
    .iss_be   (iss_be)
  );

  op_e               op1_q, op1_d, op2_q, op2_d;
  logic [ADDR_W-1:0] a1_q, a1_d, a2_q, a2_d;
  logic [BYTES-1:0]  be1_q, be1_d, be2_q, be2_d;
  logic [DW-1:0]     rdata_q, rdata_d;
  logic [DW-1:0]     arr_rd, fwd_rd;

  // write port: data slot is stage 1 in flow-through, stage 2 pipelined
  op_e               w_op;
  logic [ADDR_W-1:0] w_addr;
  logic [BYTES-1:0]  w_be;
  logic              w_en;

  assign w_op   = flow_thru ? op1_q : op2_q;
  assign w_addr = flow_thru ? a1_q  : a2_q;
  assign w_be   = flow_thru ? be1_q : be2_q;
  assign w_en   = cke_act && (w_op == OP_WR);

  zt_sram_array #(.ADDR_W(ADDR_W), .BYTES(BYTES)) i_array (
    .clk    (clk),
    .wr_en  (w_en),
    .wr_addr(w_addr),
    .wr_be  (w_be),
    .wr_data(din),
    .rd_addr(a1_q),
    .rd_data(arr_rd)
  );

  // forward the write being committed this edge into the captured read
  for (genvar b = 0; b < BYTES; b++) begin : g_fwd
    assign fwd_rd[8*b +: 8] = (op2_q == OP_WR && a2_q == a1_q && be2_q[b])
                              ? din[8*b +: 8] : arr_rd[8*b +: 8];
  end

  always_comb begin
    op1_d   = op1_q;
    a1_d    = a1_q;
    be1_d   = be1_q;
    op2_d   = op2_q;
    a2_d    = a2_q;
    be2_d   = be2_q;
    rdata_d = rdata_q;
    if (cke_act) begin
      op1_d = iss_op;
      a1_d  = iss_addr;
      be1_d = iss_be;
      op2_d = op1_q;
      a2_d  = a1_q;
      be2_d = be1_q;
      if (op1_q == OP_RD) rdata_d = fwd_rd;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      op1_q   <= OP_NONE;
      a1_q    <= '0;
      be1_q   <= '0;
      op2_q   <= OP_NONE;
      a2_q    <= '0;
      be2_q   <= '0;
      rdata_q <= '0;
    end else begin
      op1_q   <= op1_d;
      a1_q    <= a1_d;
      be1_q   <= be1_d;
      op2_q   <= op2_d;
      a2_q    <= a2_d;
      be2_q   <= be2_d;
      rdata_q <= rdata_d;
    end
  end

  op_e           d_op;
  logic [DW-1:0] d_data;
  assign d_op   = flow_thru ? op1_q  : op2_q;
  assign d_data = flow_thru ? arr_rd : rdata_q;
  assign dq_oe  = (d_op == OP_RD) && !oe_n && !asleep;
  assign dout   = dq_oe ? d_data : '0;

  // R5: a disabled edge freezes the pipeline
  a_r5_freeze: assert property (@(posedge clk) disable iff (!rst_s_n)
    !cke_act |=> ($stable(op1_q) && $stable(op2_q) && $stable(rdata_q)));

  // R10: no write enters the pipeline at a recovery edge
  a_r10_no_wr_wake: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cke_act && waking) |=> (op1_q != OP_WR));

  // R7: write data slots never drive the bus
  a_r7_hiz_write: assert property (@(posedge clk) disable iff (!rst_s_n)
    (d_op == OP_WR) |-> !dq_oe);

  // R9: nothing is driven while asleep
  a_r9_sleep_hiz: assert property (@(posedge clk) disable iff (!rst_s_n)
    asleep |-> !dq_oe);
endmodule

// File: tb/test_zt_sram.sv
module test_zt_sram;
  logic        clk = 1'b0;
  logic        rst_n, clk_en_n, cs1_n, cs2, cs3_n, load_n, we_n;
  logic [1:0]  be_n;
  logic [5:0]  addr;
  logic [15:0] din, dout;
  logic        fl, ox, oe_n, zz, dq_oe;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  zt_sram i_zt_sram (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .cs1_n(cs1_n), .cs2(cs2),
    .cs3_n(cs3_n), .load_n(load_n), .we_n(we_n), .be_n(be_n), .addr(addr),
    .din(din), .flow_thru(fl), .order_xor(ox), .oe_n(oe_n), .zz(zz),
    .dout(dout), .dq_oe(dq_oe)
  );

  // flow, order, start address, seed
  localparam logic [23:0] VEC [6] = '{
    {1'b0, 1'b0, 6'd4,  16'h1357},
    {1'b0, 1'b1, 6'd13, 16'h2468},
    {1'b1, 1'b0, 6'd22, 16'hA0A0},
    {1'b1, 1'b1, 6'd31, 16'h0F0F},
    {1'b0, 1'b1, 6'd38, 16'h7E81},
    {1'b1, 1'b0, 6'd47, 16'hC3C3}
  };

  function automatic logic [15:0] wd(input logic [15:0] seed, input int n);
    return seed ^ (16'h1111 * n[15:0]) ^ 16'h0100;
  endfunction

  function automatic logic [5:0] baddr(input logic [5:0] s, input logic x, input int n);
    logic [1:0] nn;
    nn = n[1:0];
    return {s[5:2], x ? (s[1:0] ^ nn) : (s[1:0] + nn)};
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // kind: 0 deselect load, 1 read load, 2 write load, 3 continue, 4 read with cs2 low
  task automatic drv(input int kind, input logic [5:0] a, input logic [1:0] ben,
                     input logic [15:0] d);
    cs1_n  = (kind == 0);
    cs2    = (kind != 4);
    cs3_n  = 1'b0;
    load_n = (kind == 3);
    we_n   = (kind != 2);
    be_n   = ben;
    addr   = a;
    din    = d;
  endtask

  task automatic chk(input string req, input logic eoe, input logic [15:0] exp);
    nchk++;
    if (dq_oe !== eoe || (eoe && dout !== exp)) begin
      nerr++;
      $display("FAIL %s: dq_oe=%0b dout=%h expected dq_oe=%0b dout=%h",
               req, dq_oe, dout, eoe, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      drv(0, 6'd0, 2'b11, 16'h0);
      tick();
    end
  endtask

  task automatic wr1(input logic [5:0] a, input logic [15:0] d, input logic [1:0] ben);
    int lat;
    lat = fl ? 1 : 2;
    drv(2, a, ben, 16'h0);
    tick();
    for (int i = 1; i <= lat; i++) begin
      drv(0, 6'd0, 2'b11, (i == lat) ? d : 16'h0);
      tick();
    end
  endtask

  task automatic rd1(input logic [5:0] a, input logic [15:0] exp, input string req);
    drv(1, a, 2'b11, 16'h0);
    tick();
    if (!fl) begin
      drv(0, 6'd0, 2'b11, 16'h0);
      tick();
    end
    chk(req, 1'b1, exp);
    idle(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=complete");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; clk_en_n = 1'b0; fl = 1'b0; ox = 1'b0; oe_n = 1'b0; zz = 1'b0;
    drv(0, 6'd0, 2'b11, 16'h0);
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R11 reset state, then a continue straight after reset (R6)
    chk("R11", 1'b0, 16'h0);
    drv(3, 6'd0, 2'b00, 16'h0);
    tick();
    tick();
    chk("R6", 1'b0, 16'h0);
    idle(2);

    // table: burst write, burst read, single read back
    for (int e = 0; e < 6; e++) begin
      logic [5:0]  st;
      logic [15:0] sd;
      int          lat;
      fl  = VEC[e][23];
      ox  = VEC[e][22];
      st  = VEC[e][21:16];
      sd  = VEC[e][15:0];
      lat = fl ? 1 : 2;
      idle(3);
      for (int i = 0; i < 4 + lat; i++) begin
        drv((i == 0) ? 2 : (i < 4) ? 3 : 0, st, 2'b00,
            (i >= lat) ? wd(sd, i - lat) : 16'h0);
        tick();
      end
      idle(1);
      for (int i = 0; i < 3 + lat; i++) begin
        drv((i == 0) ? 1 : (i < 4) ? 3 : 0, st, 2'b11, 16'h0);
        tick();
        if (i >= lat - 1) chk("R1 R3 burst read", 1'b1, wd(sd, i - (lat - 1)));
      end
      idle(1);
      for (int n = 0; n < 4; n++) rd1(baddr(st, ox, n), wd(sd, n), "R4 order");
    end

    // R2 byte strobes and abort, pipelined
    fl = 1'b0; ox = 1'b0;
    idle(3);
    wr1(6'd5, 16'hAAAA, 2'b00);
    wr1(6'd5, 16'h1234, 2'b10);
    rd1(6'd5, 16'hAA34, "R2 byte0 only");
    wr1(6'd5, 16'hFFFF, 2'b11);
    rd1(6'd5, 16'hAA34, "R2 abort");

    // R8 forwarding, pipelined
    drv(2, 6'd9, 2'b00, 16'h0);
    tick();
    drv(1, 6'd9, 2'b11, 16'h0);
    tick();
    drv(0, 6'd0, 2'b11, 16'hBEEF);
    tick();
    chk("R8 pipelined", 1'b1, 16'hBEEF);
    idle(3);

    // R8 forwarding, flow-through
    fl = 1'b1;
    idle(2);
    drv(2, 6'd10, 2'b00, 16'h0);
    tick();
    drv(1, 6'd10, 2'b11, 16'hCAFE);
    tick();
    chk("R8 flow", 1'b1, 16'hCAFE);
    idle(2);
    fl = 1'b0;
    idle(2);

    // R7 asynchronous output enable and write slot
    oe_n = 1'b1;
    drv(1, 6'd5, 2'b11, 16'h0);
    tick();
    drv(0, 6'd0, 2'b11, 16'h0);
    tick();
    chk("R7 oe high", 1'b0, 16'h0);
    oe_n = 1'b0;
    #1;
    chk("R7 oe async", 1'b1, 16'hAA34);
    idle(2);
    drv(2, 6'd11, 2'b00, 16'h0);
    tick();
    drv(0, 6'd0, 2'b11, 16'h0);
    tick();
    chk("R7 write slot", 1'b0, 16'h0);
    drv(0, 6'd0, 2'b11, 16'h4321);
    tick();
    rd1(6'd11, 16'h4321, "R2 full word");

    // R5 stall holds read data and drops the command
    drv(1, 6'd5, 2'b11, 16'h0);
    tick();
    drv(0, 6'd0, 2'b11, 16'h0);
    tick();
    chk("R1 pipelined", 1'b1, 16'hAA34);
    clk_en_n = 1'b1;
    drv(2, 6'd5, 2'b00, 16'h0000);
    tick();
    chk("R5 hold 1", 1'b1, 16'hAA34);
    tick();
    chk("R5 hold 2", 1'b1, 16'hAA34);
    clk_en_n = 1'b0;
    drv(0, 6'd0, 2'b11, 16'h0);
    tick();
    chk("R5 resume", 1'b0, 16'h0);
    idle(2);
    rd1(6'd5, 16'hAA34, "R5 command dropped");

    // R6 deselect and deselect continue
    drv(4, 6'd7, 2'b11, 16'h0);
    tick();
    tick();
    chk("R6 deselect", 1'b0, 16'h0);
    drv(3, 6'd0, 2'b11, 16'h0);
    tick();
    tick();
    chk("R6 continue", 1'b0, 16'h0);
    idle(2);

    // R9 and R10 sleep, flow-through
    fl = 1'b1;
    idle(2);
    wr1(6'd20, 16'h5A5A, 2'b00);
    zz = 1'b1;
    idle(2);
    drv(1, 6'd20, 2'b11, 16'h0);
    tick();
    chk("R9 asleep", 1'b0, 16'h0);
    tick();
    chk("R9 asleep", 1'b0, 16'h0);
    zz = 1'b0;
    drv(0, 6'd0, 2'b11, 16'h0);
    tick();
    drv(2, 6'd20, 2'b00, 16'h0);
    tick();
    drv(1, 6'd20, 2'b11, 16'h0);
    tick();
    chk("R10 write dropped, read kept", 1'b1, 16'h5A5A);
    idle(2);
    rd1(6'd20, 16'h5A5A, "R9 contents kept");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule